// File: doc/BRIEF.md
# Reset supervisor with watchdog

This block generates the system reset for a host processor. A clock-domain copy of an analog supply comparator tells it whether the supply is above its trip level. While the supply is low, and for a fixed hold interval after it recovers, the block asserts reset. It asserts reset on two open-drain style pins, one active high and one active low. Each pin is represented by a drive enable: when the enable is low, the pin is left to its external pull device.

Both reset pins are also sensed back. A board-level agent that pulls either pin to its active level starts a fresh hold interval. The block therefore also conditions an externally applied reset.

A watchdog counter watches one activity input. The activity input is either a dedicated strobe or the memory chip select, chosen by a strap input. If the watchdog sees no edge on that input for its timeout, it fires a reset that lasts the full hold interval. A second strap removes the watchdog altogether.

Every interval is a parameter in clock cycles, so the block can be run with small values. All asynchronous inputs pass through two synchroniser flops before use.

Top module: `rst_supervisor`

## Requirements
- R1: Out of `rst_n`, and for as long as `supply_ok` stays low, both drive enables `rst_hi_oe` and `rst_lo_oe` are 1.
- R2: When `supply_ok` rises after power-up, both enables fall exactly HOLD_CYCLES+3 clock edges after the input change. The 3 edges are two synchroniser stages plus the filter register.
- R3: A low dip of `supply_ok` lasting fewer than GLITCH_CYCLES clock cycles does not assert reset.
- R4: A sustained low on `supply_ok` asserts reset exactly GLITCH_CYCLES+3 edges after the input change. Reset stays asserted for as long as the supply is low. It is released HOLD_CYCLES+3 edges after the supply returns.
- R5: The two drive enables are always equal. A value of 1 means the pins are driven to their active levels (high on the active-high pin, low on the active-low pin).
- R6: A one-cycle external active level on either reset pin asserts reset 3 edges later. The external active level is 1 on `rst_hi_pin` and 0 on `rst_lo_pin`. Reset then holds for HOLD_CYCLES edges.
- R7: The pin sense is ignored while the block drives the pins, and for 2 cycles after release. The block's own drive therefore never re-arms reset.
- R8: With the watchdog enabled and no activity, reset asserts exactly WD_CYCLES edges after a release.
- R9: A watchdog reset is held for exactly HOLD_CYCLES edges.
- R10: The watchdog counter is held at zero while reset is asserted, so every release starts a full WD_CYCLES window.
- R11: Any edge on the selected activity source restarts the watchdog count. `wd_src_cs`=0 selects `wdi` and `wd_src_cs`=1 selects `cs`. Edges on the unselected source have no effect.
- R12: With `wd_enable`=0 the watchdog never asserts reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset of the logic |
| supply_ok | input | 1 | Comparator output, 1 when the supply is above threshold |
| rst_hi_pin | input | 1 | Sensed level of the active-high reset pin |
| rst_lo_pin | input | 1 | Sensed level of the active-low reset pin |
| wdi | input | 1 | Dedicated watchdog activity strobe |
| cs | input | 1 | Memory chip select, usable as activity source |
| wd_src_cs | input | 1 | Activity source select: 0 = wdi, 1 = cs |
| wd_enable | input | 1 | 1 enables the watchdog |
| rst_hi_oe | output | 1 | Drive enable forcing the active-high pin high |
| rst_lo_oe | output | 1 | Drive enable forcing the active-low pin low |

## Verification
Every internal counter in this block shows up directly as an edge position on the drive enables. An off-by-one in the hold counter moves every release by one cycle, so it is caught at the first power-up. A filter that counts one cycle short lets a sub-threshold dip through within GLITCH_CYCLES+3 cycles. If the counter that masks the sensed pins is missing, the block locks itself in reset at its first release. A watchdog count that is not cleared during reset shows up as a second watchdog reset arriving in fewer than WD_CYCLES cycles after a release.

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
  parameter int unsigned HOLD_CYCLES   = 2_000_000,
  parameter int unsigned GLITCH_CYCLES = 2,
  parameter int unsigned WD_CYCLES     = 16_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic rst_hi_pin,
  input  logic rst_lo_pin,
  input  logic wdi,
  input  logic cs,
  input  logic wd_src_cs,
  input  logic wd_enable,
  output logic rst_hi_oe,
  output logic rst_lo_oe
);
  localparam int HW = $clog2(HOLD_CYCLES + 1);
  localparam int GW = $clog2(GLITCH_CYCLES + 1);
  localparam int WW = $clog2(WD_CYCLES + 1);
  localparam logic [1:0] BLANK = 2'd2;

  logic [1:0] sup_sy, hi_sy, lo_sy, wdi_sy, cs_sy;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sup_sy <= '0;
      hi_sy  <= '0;
      lo_sy  <= '1;
      wdi_sy <= '0;
      cs_sy  <= '0;
    end else begin
      sup_sy <= {sup_sy[0], supply_ok};
      hi_sy  <= {hi_sy[0], rst_hi_pin};
      lo_sy  <= {lo_sy[0], rst_lo_pin};
      wdi_sy <= {wdi_sy[0], wdi};
      cs_sy  <= {cs_sy[0], cs};
    end

  logic [GW-1:0] low_cnt;
  logic under_v;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      low_cnt <= '0;
      under_v <= 1'b1;
    end else if (sup_sy[1]) begin
      low_cnt <= '0;
      under_v <= 1'b0;
    end else if (low_cnt == GW'(GLITCH_CYCLES - 1)) begin
      under_v <= 1'b1;
    end else begin
      low_cnt <= low_cnt + 1'b1;
    end

  logic rst_q;
  logic [HW-1:0] tmo;
  logic [1:0] blank;
  logic ext_req, wd_fire, trip;
  logic act, act_d, act_edge;
  logic [WW-1:0] wd_cnt;

  assign ext_req  = (blank == 2'd0) && !rst_q && (hi_sy[1] || !lo_sy[1]);
  assign act      = wd_src_cs ? cs_sy[1] : wdi_sy[1];
  assign act_edge = act ^ act_d;
  assign wd_fire  = wd_enable && !rst_q && !act_edge && (wd_cnt == WW'(WD_CYCLES - 1));
  assign trip     = under_v || ext_req || wd_fire;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) act_d <= 1'b0;
    else        act_d <= act;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                              wd_cnt <= '0;
    else if (!wd_enable || rst_q || act_edge) wd_cnt <= '0;
    else if (wd_fire)                         wd_cnt <= '0;
    else                                      wd_cnt <= wd_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rst_q <= 1'b1;
      tmo   <= '0;
      blank <= '0;
    end else if (trip) begin
      rst_q <= 1'b1;
      tmo   <= '0;
    end else if (rst_q) begin
      if (tmo == HW'(HOLD_CYCLES - 1)) begin
        rst_q <= 1'b0;
        blank <= BLANK;
      end else begin
        tmo <= tmo + 1'b1;
      end
    end else if (blank != 2'd0) begin
      blank <= blank - 1'b1;
    end

  assign rst_hi_oe = rst_q;
  assign rst_lo_oe = rst_q;

  // R4
  brownout_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    under_v |=> rst_q);
  // R3
  filter_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(under_v) |-> $past(low_cnt) == GW'(GLITCH_CYCLES - 1));
  // R2
  hold_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_q) |-> $past(tmo) == HW'(HOLD_CYCLES - 1));
  // R10
  wd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_q) |-> wd_cnt == '0);
  // R6
  ext_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req |=> rst_q && tmo == '0);
  // R8
  wd_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_fire |=> rst_q);
  // R11
  wd_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_edge && wd_enable && !rst_q) |=> wd_cnt == '0);
endmodule

// File: tb/sim_rst_supervisor.sv
module sim_rst_supervisor;
  localparam int HOLD = 40;
  localparam int GL   = 4;
  localparam int WD   = 100;

  logic clk = 0, rst_n = 0, supply_ok = 0;
  logic frc_h = 0, frc_l = 0, wdi = 0, cs = 0, wd_src_cs = 0, wd_enable = 0;
  logic oe_h, oe_l, pin_h, pin_l;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  assign pin_h = oe_h | frc_h;
  assign pin_l = ~(oe_l | frc_l);

  rst_supervisor #(.HOLD_CYCLES(HOLD), .GLITCH_CYCLES(GL), .WD_CYCLES(WD)) u0 (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok),
    .rst_hi_pin(pin_h), .rst_lo_pin(pin_l),
    .wdi(wdi), .cs(cs), .wd_src_cs(wd_src_cs), .wd_enable(wd_enable),
    .rst_hi_oe(oe_h), .rst_lo_oe(oe_l));

  // {sel, en, toggle wdi, toggle cs, expect reset}
  localparam logic [4:0] VEC [8] = '{
    5'b0_1_1_0_0, 5'b0_1_0_1_1, 5'b1_1_0_1_0, 5'b1_1_1_0_1,
    5'b0_0_0_0_0, 5'b1_0_0_0_0, 5'b0_1_1_1_0, 5'b1_1_0_0_1};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_oe(input logic want, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (oe_h !== want && n < 5000);
  endtask

  task automatic stays(input logic lvl, input int cyc, output int bad);
    bad = 0;
    repeat (cyc) begin
      @(negedge clk);
      if (oe_h !== lvl || oe_l !== lvl) bad++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL run: watchdog expired, got 150000 cycles expected fewer");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n, bad;
    bit seen;
    repeat (3) @(negedge clk);
    chk(oe_h === 1'b1 && oe_l === 1'b1, "R1", int'(oe_h), 1);
    rst_n = 1;
    stays(1'b1, 10, bad);
    chk(bad == 0, "R1", bad, 0);
    supply_ok = 1;
    wait_oe(1'b0, n);
    chk(n == HOLD + 3, "R2", n, HOLD + 3);

    supply_ok = 0;
    repeat (GL - 1) @(negedge clk);
    supply_ok = 1;
    stays(1'b0, 20, bad);
    chk(bad == 0, "R3", bad, 0);

    supply_ok = 0;
    wait_oe(1'b1, n);
    chk(n == GL + 3, "R4", n, GL + 3);
    stays(1'b1, 2 * HOLD, bad);
    chk(bad == 0, "R4", bad, 0);
    supply_ok = 1;
    wait_oe(1'b0, n);
    chk(n == HOLD + 3, "R4", n, HOLD + 3);

    frc_h = 1;
    @(negedge clk);
    frc_h = 0;
    wait_oe(1'b1, n);
    chk(n + 1 == 3, "R6", n + 1, 3);
    chk(oe_l === 1'b1, "R5", int'(oe_l), 1);
    wait_oe(1'b0, n);
    chk(n == HOLD, "R6", n, HOLD);
    chk(oe_l === 1'b0, "R5", int'(oe_l), 0);
    stays(1'b0, 20, bad);
    chk(bad == 0, "R7", bad, 0);

    frc_l = 1;
    @(negedge clk);
    frc_l = 0;
    wait_oe(1'b1, n);
    chk(n + 1 == 3, "R6", n + 1, 3);
    wait_oe(1'b0, n);
    chk(n == HOLD, "R6", n, HOLD);
    stays(1'b0, 20, bad);
    chk(bad == 0, "R7", bad, 0);

    for (int i = 0; i < 8; i++) begin
      while (oe_h) @(negedge clk);
      wd_src_cs = VEC[i][4];
      wd_enable = VEC[i][3];
      seen = 0;
      for (int j = 0; j < 2 * WD; j++) begin
        if (j % (WD / 4) == 0) begin
          if (VEC[i][2]) wdi = ~wdi;
          if (VEC[i][1]) cs = ~cs;
        end
        @(negedge clk);
        if (oe_h) seen = 1;
      end
      chk(seen == VEC[i][0], VEC[i][3] ? "R11" : "R12", int'(seen), int'(VEC[i][0]));
    end

    wd_src_cs = 0;
    wd_enable = 1;
    wait_oe(1'b1, n);
    wait_oe(1'b0, n);
    wait_oe(1'b1, n);
    chk(n == WD, "R8", n, WD);
    wait_oe(1'b0, n);
    chk(n == HOLD, "R9", n, HOLD);
    wait_oe(1'b1, n);
    chk(n == WD, "R10", n, WD);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule